// File: doc/BRIEF.md
# Dual-Rank DAC Update Controller

This block sits between a serial frame receiver and a four-channel converter core. The receiver keeps one first-rank register per channel and raises a strobe when a new word has been written. This block owns the second rank: the four registers whose contents the converter core actually shows. It decides when and how first-rank contents reach the second rank.

Two asynchronous, active-low controls steer the block. A falling edge on the load control copies every channel at once (latch mode). Holding the load control low lets each strobed channel pass straight through a fixed number of clocks after its strobe (transparent mode). A load edge that lands inside that short window after a strobe still picks up the pre-strobe contents.

The clear control forces every channel to the zero of its current output range. Each channel's stored code is then re-expressed as the offset-binary word the converter core expects. A per-channel pulse marks every change of a second-rank register.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset every second-rank channel holds data 000h in bipolar mode, presents 800h as core code, and no update pulse is raised.
- R2: Both asynchronous controls pass through a two-flop synchronizer. A low level on load_ni set up before rising edge k changes the outputs right after edge k+2. In latch mode all four channels take their snapshot at that same edge.
- R3: If the synchronized load falling edge acts at or before the second rising edge after the edge that samples strb_i, all channels receive the contents held before that strobe, not the newly strobed word.
- R4: While synchronized load is low, the channel named by addr_i (0 to 3, sampled with strb_i) copies its first-rank register at the second rising edge after the strobe edge. No other channel changes.
- R5: While synchronized clr is low, every channel's data is 000h and its mode is kept. Bipolar channels then present 800h and unipolar channels 000h. The data stays 000h after clr_ni returns high, until the next update.
- R6: Clear has priority: load edges and strobes seen while clear is active leave every channel's data and mode unchanged.
- R7: The core code equals the data with its MSB inverted in bipolar mode (mode field 2'b00), and equals the data in unipolar mode (mode field 2'b01). For example 7FFh becomes FFFh, FFFh becomes 7FFh, and 800h becomes 000h.
- R8: Mode fields 2'b10 and 2'b11 are treated as bipolar.
- R9: upd_o[ch] is high for exactly one cycle, aligned with the new output value, when channel ch's data or mode changes. Rewriting an identical value raises no pulse.

Channel ch occupies bits [ch*12 +: 12] of every data bus and bits [ch*2 +: 2] of rank1_mode_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_ni | input | 1 | Load control, asynchronous, active low |
| clr_ni | input | 1 | Clear control, asynchronous, active low |
| strb_i | input | 1 | One-cycle pulse: first-rank register addr_i was just written |
| addr_i | input | 2 | Channel written by the strobe |
| rank1_data_i | input | 48 | First-rank data, four 12-bit fields |
| rank1_mode_i | input | 8 | First-rank mode, four 2-bit fields |
| chan_data_o | output | 48 | Second-rank data per channel |
| chan_uni_o | output | 4 | Second-rank mode per channel, 1 = unipolar |
| core_code_o | output | 48 | Offset-binary code per channel for the converter core |
| upd_o | output | 4 | One-cycle change pulse per channel |

## Verification
The assertions watch the following on every cycle:
- single-cycle synchronized load edges;
- the reload and countdown of the strobe window;
- at most one transparent target;
- cleared data after every clear cycle;
- stable channels when no update is requested;
- update pulses that always coincide with a real change.

Other behaviours need the bench's scenarios. These are: the exact edge at which outputs move, the choice between old and new data around a strobe, the code conversion for each mode value, and the way clear blocks loads and strobes.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_BIP  = 2'b00,
    MODE_UNI  = 2'b01,
    MODE_RSV0 = 2'b10,
    MODE_RSV1 = 2'b11
  } mode_e;

  // reserved encodings fall back to bipolar
  function automatic logic mode_is_uni(logic [MODE_W-1:0] m);
    return m == MODE_UNI;
  endfunction
endpackage

// File: rtl/dac_sync_edge.sv
module dac_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic low_o,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= async_ni;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign low_o  = ~s2_q;
  assign fall_o = s3_q & ~s2_q;

  assert_single_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/dac_strobe_window.sv
module dac_strobe_window #(
  parameter int unsigned AW      = 2,
  parameter int unsigned WIN_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strb_i,
  input  logic [AW-1:0] addr_i,
  output logic          hold_o,
  output logic          due_o,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned CW = $clog2(WIN_CYC + 1);

  logic [CW-1:0] win_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      addr_q <= '0;
    end else if (strb_i) begin
      win_q  <= CW'(WIN_CYC);
      addr_q <= addr_i;
    end else if (win_q != '0) begin
      win_q <= win_q - CW'(1);
    end
  end

  // snapshot freezes from the strobe cycle until the window closes
  assign hold_o = strb_i | (win_q != '0);
  assign due_o  = (win_q == CW'(1));
  assign addr_o = addr_q;

  assert_window_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i |=> (win_q == CW'(WIN_CYC)) && (addr_o == $past(addr_i)));
  assert_window_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_i && win_q != '0) |=> (win_q == $past(win_q) - CW'(1)));
endmodule

// File: rtl/dac_rank2_chan.sv
module dac_rank2_chan #(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          latch_i,
  input  logic          trans_i,
  input  logic [DW-1:0] snap_data_i,
  input  logic          snap_uni_i,
  input  logic [DW-1:0] new_data_i,
  input  logic          new_uni_i,
  output logic [DW-1:0] data_o,
  output logic          uni_o,
  output logic [DW-1:0] core_o,
  output logic          upd_o
);
  logic [DW-1:0] data_q, data_d;
  logic          uni_q, uni_d, upd_q;

  // priority: clear, then latch, then transparent
  always_comb begin
    data_d = data_q;
    uni_d  = uni_q;
    if (clr_i) begin
      data_d = '0;
    end else if (latch_i) begin
      data_d = snap_data_i;
      uni_d  = snap_uni_i;
    end else if (trans_i) begin
      data_d = new_data_i;
      uni_d  = new_uni_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      uni_q  <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      uni_q  <= uni_d;
      upd_q  <= (data_d != data_q) || (uni_d != uni_q);
    end
  end

  assign data_o = data_q;
  assign uni_o  = uni_q;
  assign upd_o  = upd_q;
  assign core_o = uni_q ? data_q : {~data_q[DW-1], data_q[DW-2:0]};

  assert_clear_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (data_o == '0) && $stable(uni_o));
  assert_idle_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !latch_i && !trans_i) |=> $stable(data_o) && $stable(uni_o));
  assert_pulse_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> (data_o != $past(data_o)) || (uni_o != $past(uni_o)));
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dac_upd_pkg::*;
#(
  parameter int unsigned NCH     = 4,
  parameter int unsigned DW      = 12,
  parameter int unsigned WIN_CYC = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_ni,
  input  logic                   clr_ni,
  input  logic                   strb_i,
  input  logic [$clog2(NCH)-1:0] addr_i,
  input  logic [NCH*DW-1:0]      rank1_data_i,
  input  logic [NCH*MODE_W-1:0]  rank1_mode_i,
  output logic [NCH*DW-1:0]      chan_data_o,
  output logic [NCH-1:0]         chan_uni_o,
  output logic [NCH*DW-1:0]      core_code_o,
  output logic [NCH-1:0]         upd_o
);
  localparam int unsigned AW = $clog2(NCH);

  logic          load_low, load_fall, clr_low, clr_fall;
  logic          snap_hold, due;
  logic [AW-1:0] addr_q;
  logic [NCH-1:0] trans_vec;

  dac_sync_edge u_load_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_ni (load_ni),
    .low_o    (load_low),
    .fall_o   (load_fall)
  );

  dac_sync_edge u_clr_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_ni (clr_ni),
    .low_o    (clr_low),
    .fall_o   (clr_fall)
  );

  dac_strobe_window #(.AW(AW), .WIN_CYC(WIN_CYC)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strb_i (strb_i),
    .addr_i (addr_i),
    .hold_o (snap_hold),
    .due_o  (due),
    .addr_o (addr_q)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [DW-1:0] r1_data, snap_data_q;
    logic          r1_uni, snap_uni_q;

    assign r1_data = rank1_data_i[ch*DW +: DW];
    assign r1_uni  = mode_is_uni(rank1_mode_i[ch*MODE_W +: MODE_W]);

    // pre-strobe copy used by latch-mode loads
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        snap_data_q <= '0;
        snap_uni_q  <= 1'b0;
      end else if (!snap_hold) begin
        snap_data_q <= r1_data;
        snap_uni_q  <= r1_uni;
      end
    end

    assign trans_vec[ch] = load_low & due & (addr_q == AW'(ch));

    dac_rank2_chan #(.DW(DW)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (clr_low),
      .latch_i     (load_fall),
      .trans_i     (trans_vec[ch]),
      .snap_data_i (snap_data_q),
      .snap_uni_i  (snap_uni_q),
      .new_data_i  (r1_data),
      .new_uni_i   (r1_uni),
      .data_o      (chan_data_o[ch*DW +: DW]),
      .uni_o       (chan_uni_o[ch]),
      .core_o      (core_code_o[ch*DW +: DW]),
      .upd_o       (upd_o[ch])
    );
  end

  assert_one_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trans_vec));
  assert_clear_on_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_fall |=> (chan_data_o == '0));
endmodule

// File: tb/dac_update_ctrl_tb.sv
module dac_update_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_ni = 1'b1, clr_ni = 1'b1, strb_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [47:0] r1_data = '0;
  logic [7:0]  r1_mode = '0;
  logic [47:0] chan_data_o, core_code_o;
  logic [3:0]  chan_uni_o, upd_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [11:0] m_data [4];
  logic        m_uni  [4];

  always #5 clk = ~clk;

  dac_update_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_ni(load_ni), .clr_ni(clr_ni),
    .strb_i(strb_i), .addr_i(addr_i), .rank1_data_i(r1_data), .rank1_mode_i(r1_mode),
    .chan_data_o(chan_data_o), .chan_uni_o(chan_uni_o), .core_code_o(core_code_o), .upd_o(upd_o)
  );

  // {addr, mode, data, expected core code}
  localparam logic [27:0] VEC [10] = '{
    {2'd0, 2'b00, 12'h7FF, 12'hFFF},
    {2'd1, 2'b00, 12'h000, 12'h800},
    {2'd2, 2'b00, 12'hFFF, 12'h7FF},
    {2'd3, 2'b00, 12'h800, 12'h000},
    {2'd0, 2'b01, 12'hFFF, 12'hFFF},
    {2'd1, 2'b01, 12'h800, 12'h800},
    {2'd2, 2'b01, 12'h000, 12'h000},
    {2'd3, 2'b10, 12'h001, 12'h801},
    {2'd3, 2'b11, 12'h001, 12'h801},
    {2'd2, 2'b01, 12'h000, 12'h000}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] core_of(input logic [11:0] d, input logic u);
    return u ? d : (d ^ 12'h800);
  endfunction

  task automatic set_r1(input int a, input logic [11:0] d, input logic [1:0] m);
    r1_data[a*12 +: 12] = d;
    r1_mode[a*2 +: 2]   = m;
  endtask

  task automatic chk_all(input string req);
    for (int c = 0; c < 4; c++) begin
      chk(chan_data_o[c*12 +: 12] == m_data[c], req, chan_data_o[c*12 +: 12], m_data[c]);
      chk(chan_uni_o[c] == m_uni[c], req, chan_uni_o[c], m_uni[c]);
      chk(core_code_o[c*12 +: 12] == core_of(m_data[c], m_uni[c]), req,
          core_code_o[c*12 +: 12], core_of(m_data[c], m_uni[c]));
    end
  endtask

  task automatic strobe(input int a, input logic [11:0] d, input logic [1:0] m);
    set_r1(a, d, m);
    addr_i = 2'(a);
    strb_i = 1'b1;
    step(1);
    strb_i = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin m_data[c] = '0; m_uni[c] = 1'b0; end
    step(3);
    rst_ni = 1'b1;
    step(1);
    chk_all("R1 reset state");
    chk(upd_o == 4'h0, "R1 no pulse", upd_o, 4'h0);

    // transparent mode walk
    load_ni = 1'b0;
    step(4);
    chk(upd_o == 4'h0, "R9 identical latch no pulse", upd_o, 4'h0);
    for (int i = 0; i < 10; i++) begin
      int a;
      logic [1:0] m;
      logic [11:0] d, cexp;
      logic u, chg;
      a = int'(VEC[i][27:26]); m = VEC[i][25:24]; d = VEC[i][23:12]; cexp = VEC[i][11:0];
      u = (m == 2'b01);
      chg = (m_data[a] != d) || (m_uni[a] != u);
      strobe(a, d, m);
      step(1);
      chk_all("R4 not before second edge");
      step(1);
      m_data[a] = d; m_uni[a] = u;
      chk_all("R4 addressed channel only");
      chk(core_code_o[a*12 +: 12] == cexp, "R7 R8 core code", core_code_o[a*12 +: 12], cexp);
      chk(upd_o == (chg ? (4'b1 << a) : 4'b0), "R9 pulse on change", upd_o, chg ? (4'b1 << a) : 4'b0);
      step(1);
      chk(upd_o == 4'h0, "R9 one cycle", upd_o, 4'h0);
    end

    // latch mode: all channels together
    load_ni = 1'b1;
    step(4);
    set_r1(0, 12'h123, 2'b00); set_r1(1, 12'h456, 2'b01);
    set_r1(2, 12'h89A, 2'b00); set_r1(3, 12'hFED, 2'b01);
    step(4);
    chk_all("R2 held while load high");
    load_ni = 1'b0;
    step(2);
    chk_all("R2 not before third edge");
    step(1);
    m_data = '{12'h123, 12'h456, 12'h89A, 12'hFED};
    m_uni  = '{1'b0, 1'b1, 1'b0, 1'b1};
    chk_all("R2 all channels at once");
    chk(upd_o == 4'hF, "R9 latch pulses", upd_o, 4'hF);

    // load edge inside strobe window picks old data
    load_ni = 1'b1;
    step(4);
    load_ni = 1'b0;
    strobe(1, 12'h0AB, 2'b00);
    step(2);
    chk_all("R3 old data kept");
    chk(upd_o == 4'h0, "R3 no change pulse", upd_o, 4'h0);
    step(2);
    chk_all("R3 still old");
    load_ni = 1'b1;
    step(4);
    load_ni = 1'b0;
    step(3);
    m_data[1] = 12'h0AB; m_uni[1] = 1'b0;
    chk_all("R3 later edge takes new data");
    chk(upd_o == 4'b0010, "R9 only ch1 pulses", upd_o, 4'b0010);

    // clear
    load_ni = 1'b1;
    step(3);
    clr_ni = 1'b0;
    step(3);
    for (int c = 0; c < 4; c++) m_data[c] = '0;
    chk_all("R5 clear to zero code");
    chk(core_code_o[3*12 +: 12] == 12'h000, "R5 unipolar zero", core_code_o[3*12 +: 12], 12'h000);
    chk(core_code_o[0 +: 12] == 12'h800, "R5 bipolar zero", core_code_o[0 +: 12], 12'h800);
    chk(upd_o == 4'hF, "R9 clear pulses", upd_o, 4'hF);
    load_ni = 1'b0;
    step(4);
    strobe(3, 12'h555, 2'b00);
    step(4);
    chk_all("R6 load and strobe ignored in clear");
    clr_ni = 1'b1;
    step(4);
    chk_all("R5 zero held after release");
    strobe(0, 12'h321, 2'b01);
    step(2);
    m_data[0] = 12'h321; m_uni[0] = 1'b1;
    chk_all("R4 transparent after clear");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule